// File: doc/BRIEF.md
# DMA Channel Chaining Controller

This block sequences one DMA channel. It holds a 16-bit control word and a remaining-word counter. A host write starts the channel, and another host write can stop it. While the channel runs, each word-transferred strobe from the datapath lowers the counter. When the counter runs out, the block may pulse end of transfer. It then either returns to idle or chains to the next instruction, which it reads word by word from a shared instruction store.

A chain load copies six words of the selected instruction into the channel. Those words are the control word, the count, and two address/extension pairs. Instruction n starts at store word n*8. The address words are only held and read back here, because address generation belongs to the datapath. The instruction-store read port is valid/ready. The block raises `fetch_req_valid` with an address and keeps both steady until `fetch_req_ready` is sampled high. At most one request is outstanding. The store must answer an accepted request with exactly one `fetch_rsp_valid` cycle, at least one cycle later. The block always accepts a response while it waits, so the response side has no ready.

Top module: `dma_chain_ctrl`

## Requirements
- R1: The control word bits are: 15 run/active, 14:12 mode code, 11:10 area-1 direction, 9:8 area-2 direction, 7 signal-every-block, 6 chain, 5:0 next-instruction pointer. Reading host address 0 returns the stored fields, with bit 15 showing whether the channel is active. Address 1 is the count. Addresses 2 to 5 are the two address/extension pairs. Addresses 6 and 7 read as 0.
- R2: After reset the channel is idle, `eot` is low and no fetch is requested. While idle, a write to address 0 stores all fields. If the write has bit 15 set and a mode code other than 011, the channel becomes active from the next cycle.
- R3: A start write with mode code 011 leaves the channel idle.
- R4: A write to address 0 with bit 15 clear stops an active channel from the next cycle, without an `eot` pulse.
- R5: Each `word_done` while running lowers the count by one. A strobe seen with the count at 1 or 0 ends the block and leaves the count at 0. A strobe in the same cycle as a host write to address 0 or 1 is dropped.
- R6: `eot` is a one-cycle pulse in the cycle after the block-ending strobe. With bit 7 set it occurs at every block end. With bit 7 clear it occurs only when the block does not chain.
- R7: A block end that does not chain returns the channel to idle in the same cycle as the `eot` pulse.
- R8: A block end chains when bit 6 is set and the pointer is below 60. The block then requests store words ptr*8+0 through ptr*8+5, in that order, and loads them into the control word (bit 15 ignored), count, and address words 2 to 5. The channel stays active throughout and counting resumes after the sixth word. Strobes during the load are ignored.
- R9: Pointer values 60 to 63 never chain: the block ends with `eot` and the channel goes idle.
- R10: A write to address 0 while active changes no field except the chain bit, which is ANDed with bit 6 of the written data.
- R11: `err` while active makes the channel idle from the next cycle, with no `eot`, and abandons any load in progress.
- R12: `fetch_req_valid` and `fetch_req_addr` stay unchanged until the request is accepted, unless an error or a stop aborts the load.
- R13: While idle, `word_done` and `err` have no effect on the count or on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register select, used for writes and reads |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for `host_addr` (combinational) |
| word_done | input | 1 | One word transferred by the datapath |
| err | input | 1 | Transfer error |
| eot | output | 1 | End-of-transfer pulse |
| fetch_req_valid | output | 1 | Instruction-store read request valid |
| fetch_req_ready | input | 1 | Store accepts the request |
| fetch_req_addr | output | 9 | Store word address (pointer*8 + word) |
| fetch_rsp_valid | input | 1 | Store returns one word |
| fetch_rsp_data | input | 16 | Returned store word |

## Verification
The chaining path is tried in three ways. The first is a single link with signal-every-block clear, which must give no pulse at the link and one pulse at the end. The second is a two-link chain with the bit set on the first instruction, which must give a pulse at the first block end and at the last block end. The third uses reserved pointers, which must end like a plain block. The store stalls its ready every third cycle during these loads, which separates a correct hold of the request from a design that advances on valid alone. Plain blocks are run with counts of 3 and 0 to exercise the decrement and the zero-count boundary. Stops and errors are injected during running and during a load, and strobes and errors are sent to an idle channel to show they change nothing.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int WORD_W = 16;
  localparam int HA_W   = 3;
  localparam int PTR_W  = 6;

  localparam logic [HA_W-1:0] HA_CTL   = 3'd0;
  localparam logic [HA_W-1:0] HA_COUNT = 3'd1;
  localparam logic [2:0]      CODE_UNUSED = 3'b011;

  typedef struct packed {
    logic             run;
    logic [2:0]       code;
    logic [1:0]       src_dir;
    logic [1:0]       dst_dir;
    logic             eot_every;
    logic             link;
    logic [PTR_W-1:0] link_ptr;
  } ctl_word_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_REQ, SQ_WAIT} sq_state_t;
endpackage

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
  import dma_chain_pkg::*;
#(
  parameter int LOAD_WORDS = 6,
  parameter int IDX_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              host_wr,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              load_en,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic [WORD_W-1:0] load_data,
  input  logic [WORD_W-1:0] count,
  output ctl_word_t         ctl,
  output logic [WORD_W-1:0] host_rdata
);
  localparam int NUM_ADDR = LOAD_WORDS - 2;

  ctl_word_t ctl_q;
  ctl_word_t wr_word;
  ctl_word_t ld_word;
  logic [WORD_W-1:0] addr_q [NUM_ADDR];

  assign wr_word = ctl_word_t'(host_wdata);
  assign ld_word = ctl_word_t'(load_data);
  assign ctl     = ctl_q;

  // Control word: full write while idle, chain-bit masking while busy.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (host_wr && host_addr == HA_CTL) begin
      if (!busy) begin
        ctl_q     <= wr_word;
        ctl_q.run <= 1'b0;
      end else begin
        ctl_q.link <= ctl_q.link & wr_word.link;
      end
    end else if (load_en && load_idx == '0) begin
      ctl_q     <= ld_word;
      ctl_q.run <= 1'b0;
    end
  end

  // Address/extension words; host write wins over a chain load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ADDR; i++) addr_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_ADDR; i++) begin
        if (host_wr && host_addr == HA_W'(i + 2))
          addr_q[i] <= host_wdata;
        else if (load_en && load_idx == IDX_W'(i + 2))
          addr_q[i] <= load_data;
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == HA_CTL)
      host_rdata = {busy, ctl_q[WORD_W-2:0]};
    else if (host_addr == HA_COUNT)
      host_rdata = count;
    for (int i = 0; i < NUM_ADDR; i++)
      if (host_addr == HA_W'(i + 2)) host_rdata = addr_q[i];
  end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int NUM_INSTR  = 60,
  parameter int SLOT_SHIFT = 3,
  parameter int LOAD_WORDS = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_wr,
  input  logic [HA_W-1:0]             host_addr,
  input  logic [WORD_W-1:0]           host_wdata,
  input  logic                        word_done,
  input  logic                        err,
  input  ctl_word_t                   ctl,
  input  logic                        fetch_req_ready,
  input  logic                        fetch_rsp_valid,
  input  logic [WORD_W-1:0]           fetch_rsp_data,
  output logic                        busy,
  output logic                        eot,
  output logic                        fetch_req_valid,
  output logic [PTR_W+SLOT_SHIFT-1:0] fetch_req_addr,
  output logic                        load_en,
  output logic [SLOT_SHIFT-1:0]       load_idx,
  output logic [WORD_W-1:0]           count
);
  sq_state_t st_q, st_d;
  logic [WORD_W-1:0]     cnt_q;
  logic [PTR_W-1:0]      ptr_q;
  logic [SLOT_SHIFT-1:0] idx_q;
  logic                  eot_q;
  ctl_word_t             wr_word;

  logic ctl_hit, count_hit, start, stop, fault;
  logic run_strobe, block_end, chain_ok, load_fire, last_word;

  assign wr_word    = ctl_word_t'(host_wdata);
  assign ctl_hit    = host_wr && host_addr == HA_CTL;
  assign count_hit  = host_wr && host_addr == HA_COUNT;
  assign start      = st_q == SQ_IDLE && ctl_hit && wr_word.run && wr_word.code != CODE_UNUSED;
  assign stop       = st_q != SQ_IDLE && ctl_hit && !wr_word.run;
  assign fault      = st_q != SQ_IDLE && err;
  assign run_strobe = st_q == SQ_RUN && word_done && !err && !ctl_hit && !count_hit;
  assign block_end  = run_strobe && cnt_q <= WORD_W'(1);
  assign chain_ok   = ctl.link && ctl.link_ptr < PTR_W'(NUM_INSTR);
  assign load_fire  = st_q == SQ_WAIT && fetch_rsp_valid && !fault && !stop;
  assign last_word  = idx_q == SLOT_SHIFT'(LOAD_WORDS - 1);

  always_comb begin
    st_d = st_q;
    if (fault || stop) begin
      st_d = SQ_IDLE;
    end else if (start) begin
      st_d = SQ_RUN;
    end else begin
      unique case (st_q)
        SQ_RUN:  if (block_end) st_d = chain_ok ? SQ_REQ : SQ_IDLE;
        SQ_REQ:  if (fetch_req_ready) st_d = SQ_WAIT;
        SQ_WAIT: if (load_fire) st_d = last_word ? SQ_RUN : SQ_REQ;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      eot_q <= 1'b0;
      ptr_q <= '0;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      eot_q <= block_end && (ctl.eot_every || !chain_ok);
      if (block_end && chain_ok) ptr_q <= ctl.link_ptr;
      if (block_end) idx_q <= '0;
      else if (load_fire) idx_q <= idx_q + 1'b1;
      if (count_hit) cnt_q <= host_wdata;
      else if (run_strobe) cnt_q <= block_end ? '0 : cnt_q - 1'b1;
      else if (load_fire && idx_q == SLOT_SHIFT'(1)) cnt_q <= fetch_rsp_data;
    end
  end

  assign busy            = st_q != SQ_IDLE;
  assign eot             = eot_q;
  assign fetch_req_valid = st_q == SQ_REQ;
  assign fetch_req_addr  = {ptr_q, idx_q};
  assign load_en         = load_fire;
  assign load_idx        = idx_q;
  assign count           = cnt_q;
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
#(
  parameter int NUM_INSTR  = 60,
  parameter int SLOT_SHIFT = 3,
  parameter int LOAD_WORDS = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_wr,
  input  logic [HA_W-1:0]             host_addr,
  input  logic [WORD_W-1:0]           host_wdata,
  output logic [WORD_W-1:0]           host_rdata,
  input  logic                        word_done,
  input  logic                        err,
  output logic                        eot,
  output logic                        fetch_req_valid,
  input  logic                        fetch_req_ready,
  output logic [PTR_W+SLOT_SHIFT-1:0] fetch_req_addr,
  input  logic                        fetch_rsp_valid,
  input  logic [WORD_W-1:0]           fetch_rsp_data
);
  ctl_word_t             ctl;
  logic                  busy;
  logic                  load_en;
  logic [SLOT_SHIFT-1:0] load_idx;
  logic [WORD_W-1:0]     count;

  dma_chain_seq #(
    .NUM_INSTR(NUM_INSTR), .SLOT_SHIFT(SLOT_SHIFT), .LOAD_WORDS(LOAD_WORDS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .word_done(word_done), .err(err), .ctl(ctl),
    .fetch_req_ready(fetch_req_ready), .fetch_rsp_valid(fetch_rsp_valid),
    .fetch_rsp_data(fetch_rsp_data),
    .busy(busy), .eot(eot), .fetch_req_valid(fetch_req_valid),
    .fetch_req_addr(fetch_req_addr), .load_en(load_en), .load_idx(load_idx),
    .count(count)
  );

  dma_chain_regs #(
    .LOAD_WORDS(LOAD_WORDS), .IDX_W(SLOT_SHIFT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .load_en(load_en), .load_idx(load_idx), .load_data(fetch_rsp_data),
    .count(count), .ctl(ctl), .host_rdata(host_rdata)
  );
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk
  import dma_chain_pkg::*;
#(
  parameter int NUM_INSTR  = 60,
  parameter int SLOT_SHIFT = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        busy,
  input logic                        host_wr,
  input logic [HA_W-1:0]             host_addr,
  input logic [WORD_W-1:0]           host_wdata,
  input logic                        word_done,
  input logic                        err,
  input logic                        eot,
  input logic                        fetch_req_valid,
  input logic                        fetch_req_ready,
  input logic [PTR_W+SLOT_SHIFT-1:0] fetch_req_addr
);
  logic ctl_stop_wr;
  assign ctl_stop_wr = host_wr && host_addr == HA_CTL && !host_wdata[15];

  assert_eot_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> !eot);

  assert_eot_after_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> $past(word_done));

  assert_unused_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && host_wr && host_addr == HA_CTL && host_wdata[14:12] == CODE_UNUSED) |=> !busy);

  assert_stop_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !err && ctl_stop_wr) |=> (!busy && !eot));

  assert_err_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && err) |=> (!busy && !eot));

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req_valid && !fetch_req_ready && !err && !ctl_stop_wr)
      |=> (fetch_req_valid && $stable(fetch_req_addr)));

  assert_no_reserved_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_valid |-> (fetch_req_addr[PTR_W+SLOT_SHIFT-1:SLOT_SHIFT] < PTR_W'(NUM_INSTR)));

  assert_idle_no_fetch_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fetch_req_valid);
endmodule

bind dma_chain_ctrl dma_chain_chk #(
  .NUM_INSTR(NUM_INSTR), .SLOT_SHIFT(SLOT_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
  .word_done(word_done), .err(err), .eot(eot),
  .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
  .fetch_req_addr(fetch_req_addr)
);

// File: tb/tb_dma_chain_ctrl.sv
module tb_dma_chain_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        word_done = 1'b0;
  logic        err = 1'b0;
  logic        eot;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [8:0]  req_addr;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .word_done(word_done),
    .err(err), .eot(eot), .fetch_req_valid(req_valid), .fetch_req_ready(req_ready),
    .fetch_req_addr(req_addr), .fetch_rsp_valid(rsp_valid), .fetch_rsp_data(rsp_data)
  );

  int n_chk = 0, n_fail = 0, eot_seen = 0, cyc = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [15:0] mk(bit run, logic [2:0] code, bit every, bit link, logic [5:0] p);
    return {run, code, 2'b01, 2'b10, every, link, p};
  endfunction

  // Instruction store: one request at a time, answered one cycle after acceptance.
  logic [15:0] mem [512];
  bit st_stall = 0;
  bit pend = 0;
  int paddr = 0, stall_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      rsp_valid = 0; pend = 0; req_ready = 1;
    end else begin
      rsp_valid = 0;
      if (pend) begin rsp_valid = 1; rsp_data = mem[paddr]; pend = 0; end
      req_ready = st_stall ? (stall_cnt % 3 != 0) : 1'b1;
      stall_cnt++;
      if (req_valid && req_ready) begin pend = 1; paddr = int'(req_addr); end
    end
  end

  // Behavioural reference model, updated on each rising edge.
  bit m_active, m_eot, m_fetch;
  logic [15:0] m_ctl, m_count;
  logic [15:0] m_words [2:5];
  int m_idx, m_ptr;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_eot = 0; m_fetch = 0; m_ctl = 0; m_count = 0;
      m_idx = 0; m_ptr = 0;
      for (int i = 2; i <= 5; i++) m_words[i] = 0;
    end else begin
      bit ctl_w, cnt_w, chain;
      ctl_w = host_wr && host_addr == 3'd0;
      cnt_w = host_wr && host_addr == 3'd1;
      m_eot = 0;
      if (cnt_w) m_count = host_wdata;
      if (err && m_active) begin
        m_active = 0; m_fetch = 0;
      end else begin
        if (ctl_w) begin
          if (!m_active) begin
            m_ctl = host_wdata & 16'h7FFF;
            if (host_wdata[15] && host_wdata[14:12] != 3'b011) m_active = 1;
          end else begin
            m_ctl[6] = m_ctl[6] & host_wdata[6];
            if (!host_wdata[15]) begin m_active = 0; m_fetch = 0; end
          end
        end
        if (host_wr && host_addr >= 3'd2 && host_addr <= 3'd5) m_words[int'(host_addr)] = host_wdata;
        if (!ctl_w && !cnt_w && m_active && !m_fetch && word_done) begin
          if (m_count <= 1) begin
            m_count = 0;
            chain = m_ctl[6] && m_ctl[5:0] < 6'd60;
            m_eot = m_ctl[7] || !chain;
            if (chain) begin m_fetch = 1; m_idx = 0; m_ptr = int'(m_ctl[5:0]); end
            else m_active = 0;
          end else begin
            m_count = m_count - 1;
          end
        end else if (m_fetch && rsp_valid) begin
          if (m_idx == 0) m_ctl = rsp_data & 16'h7FFF;
          else if (m_idx == 1) m_count = rsp_data;
          else m_words[m_idx] = rsp_data;
          m_idx++;
          if (m_idx == 6) m_fetch = 0;
        end
      end
    end
  end

  // Per-cycle comparison, away from the rising edge.
  always @(negedge clk) begin
    #2;
    cyc++;
    if (rst_n) begin
      logic [15:0] exp_rd;
      case (host_addr)
        3'd0: exp_rd = {m_active, m_ctl[14:0]};
        3'd1: exp_rd = m_count;
        3'd2, 3'd3, 3'd4, 3'd5: exp_rd = m_words[int'(host_addr)];
        default: exp_rd = 16'h0;
      endcase
      check("R6 eot per cycle", eot, m_eot);
      check(host_addr == 3'd0 ? "R1 control word readback" :
            host_addr == 3'd1 ? "R5 count readback" : "R8 address word readback",
            host_rdata, exp_rd);
      check("R12 request only while loading", req_valid, req_valid & m_fetch);
      if (req_valid) check("R8 fetch address", req_addr, m_ptr * 8 + m_idx);
      if (eot) eot_seen++;
    end
    if (cyc > WATCHDOG) begin
      n_fail++;
      $display("FAIL R8 watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
      report();
      $finish;
    end
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0; host_addr = 3'd0;
  endtask
  task automatic strobe();
    @(negedge clk); word_done = 1;
    @(negedge clk); word_done = 0;
  endtask
  task automatic pulse_err();
    @(negedge clk); err = 1;
    @(negedge clk); err = 0;
  endtask
  task automatic rd(logic [2:0] a, output logic [15:0] v);
    @(negedge clk); host_addr = a; #3; v = host_rdata;
  endtask
  task automatic put_instr(int p, logic [15:0] w0, logic [15:0] w1, logic [15:0] w2,
                           logic [15:0] w3, logic [15:0] w4, logic [15:0] w5);
    mem[p*8+0] = w0; mem[p*8+1] = w1; mem[p*8+2] = w2;
    mem[p*8+3] = w3; mem[p*8+4] = w4; mem[p*8+5] = w5;
  endtask

  initial begin
    logic [15:0] v;
    int e0;
    for (int i = 0; i < 512; i++) mem[i] = 16'((i * 37 + 5) & 16'hFFFF);
    put_instr(5, mk(0, 3'd2, 1, 0, 6'd0), 16'd2, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    put_instr(7, mk(1, 3'd0, 0, 1, 6'd9), 16'd1, 16'h7A7A, 16'h7B7B, 16'h7C7C, 16'h7D7D);
    put_instr(9, mk(0, 3'd1, 0, 0, 6'd0), 16'd1, 16'h9A9A, 16'h9B9B, 16'h9C9C, 16'h9D9D);

    repeat (3) @(negedge clk);
    #3;
    check("R2 reset eot", eot, 0);
    check("R2 reset no fetch", req_valid, 0);
    check("R2 reset control word", host_rdata, 16'h0);
    @(negedge clk); rst_n = 1;

    // Plain block of three words.
    wr(3'd1, 16'd3); wr(3'd2, 16'hA1A1);
    wr(3'd0, mk(1, 3'd0, 0, 0, 6'd0));
    rd(3'd0, v); check("R2 started active", v[15], 1);
    check("R1 control word fields", v, mk(1, 3'd0, 0, 0, 6'd0));
    e0 = eot_seen;
    strobe(); strobe();
    rd(3'd1, v); check("R5 count after two words", v, 16'd1);
    strobe();
    rd(3'd0, v); check("R7 idle after last word", v[15], 0);
    check("R6 one eot for plain block", eot_seen - e0, 1);
    rd(3'd6, v); check("R1 unused address reads zero", v, 16'h0);

    // Unused mode code.
    wr(3'd1, 16'd4);
    wr(3'd0, mk(1, 3'b011, 0, 0, 6'd0));
    rd(3'd0, v); check("R3 code 011 stays idle", v[15], 0);

    // Host stop.
    wr(3'd1, 16'd5);
    wr(3'd0, mk(1, 3'd1, 0, 0, 6'd0));
    strobe();
    e0 = eot_seen;
    wr(3'd0, mk(0, 3'd1, 0, 0, 6'd0));
    rd(3'd0, v); check("R4 stopped", v[15], 0);
    check("R4 no eot on stop", eot_seen - e0, 0);
    rd(3'd1, v); check("R4 count held", v, 16'd4);

    // Idle channel ignores strobes and errors.
    strobe(); strobe(); pulse_err();
    rd(3'd1, v); check("R13 count unchanged while idle", v, 16'd4);
    check("R13 no eot while idle", eot_seen - e0, 0);

    // Single chain link with stalling store.
    st_stall = 1;
    wr(3'd1, 16'd1);
    wr(3'd0, mk(1, 3'd0, 0, 1, 6'd5));
    e0 = eot_seen;
    strobe(); strobe();
    repeat (40) @(negedge clk);
    check("R6 no eot at chained end", eot_seen - e0, 0);
    rd(3'd0, v); check("R8 loaded control word", v, mk(1, 3'd2, 1, 0, 6'd0));
    rd(3'd1, v); check("R8 loaded count, strobe during load ignored", v, 16'd2);
    rd(3'd2, v); check("R8 loaded area-1 address", v, 16'h1111);
    rd(3'd5, v); check("R8 loaded area-2 extension", v, 16'h4444);
    strobe(); strobe();
    rd(3'd0, v); check("R7 idle after chained block", v[15], 0);
    check("R6 eot at final block", eot_seen - e0, 1);

    // Two links, signal-every-block set on the first.
    wr(3'd1, 16'd1);
    wr(3'd0, mk(1, 3'd0, 1, 1, 6'd7));
    e0 = eot_seen;
    strobe();
    rd(3'd0, v); check("R8 active while loading", v[15], 1);
    check("R6 eot at chained end with every-block set", eot_seen - e0, 1);
    repeat (40) @(negedge clk);
    strobe();
    repeat (40) @(negedge clk);
    check("R6 no eot at second link", eot_seen - e0, 1);
    rd(3'd3, v); check("R8 second link address", v, 16'h9B9B);
    strobe();
    rd(3'd0, v); check("R7 idle after two links", v[15], 0);
    check("R6 eot total for two links", eot_seen - e0, 2);
    st_stall = 0;

    // Reserved pointers.
    wr(3'd1, 16'd1);
    wr(3'd0, mk(1, 3'd0, 0, 1, 6'h3C));
    e0 = eot_seen;
    strobe();
    rd(3'd0, v); check("R9 pointer 3C ends", v[15], 0);
    check("R9 pointer 3C eot", eot_seen - e0, 1);
    wr(3'd1, 16'd1);
    wr(3'd0, mk(1, 3'd0, 0, 1, 6'h3F));
    strobe();
    rd(3'd0, v); check("R9 pointer 3F ends", v[15], 0);
    check("R9 pointer 3F eot", eot_seen - e0, 2);

    // Control write while active.
    wr(3'd1, 16'd2);
    wr(3'd0, mk(1, 3'd0, 0, 1, 6'd5));
    wr(3'd0, mk(1, 3'd4, 1, 1, 6'd9));
    rd(3'd0, v); check("R10 chain kept, fields unchanged", v, mk(1, 3'd0, 0, 1, 6'd5));
    wr(3'd0, mk(1, 3'd0, 0, 0, 6'd5));
    rd(3'd0, v); check("R10 chain suppressed", v, mk(1, 3'd0, 0, 0, 6'd5));
    e0 = eot_seen;
    strobe(); strobe();
    rd(3'd0, v); check("R10 suppressed chain ends idle", v[15], 0);
    check("R10 eot after suppressed chain", eot_seen - e0, 1);

    // Errors while running and while loading.
    wr(3'd1, 16'd5);
    wr(3'd0, mk(1, 3'd0, 0, 0, 6'd0));
    strobe();
    e0 = eot_seen;
    pulse_err();
    rd(3'd0, v); check("R11 error stops run", v[15], 0);
    check("R11 no eot on error", eot_seen - e0, 0);
    wr(3'd1, 16'd1);
    wr(3'd0, mk(1, 3'd0, 0, 1, 6'd5));
    strobe();
    repeat (2) @(negedge clk);
    pulse_err();
    repeat (10) @(negedge clk);
    rd(3'd0, v); check("R11 error abandons load", v[15], 0);

    // Zero count ends on first strobe.
    wr(3'd1, 16'd0);
    wr(3'd0, mk(1, 3'd5, 0, 0, 6'd0));
    e0 = eot_seen;
    strobe();
    rd(3'd0, v); check("R5 zero count ends on first word", v[15], 0);
    check("R5 zero count eot", eot_seen - e0, 1);

    repeat (4) @(negedge clk);
    report();
    $finish;
  end
endmodule